// File: doc/BRIEF.md
# Collision Pair Serialiser

This block sits after a parallel box-overlap comparator. In any cycle the comparator may report a colliding pair of box indices on each of its lanes. The block collects these pairs and sends them out as one serial stream of index words, ready to be written into a memory that the host reads. Each lane has two small queues, one for each index of a pair. All lanes can be written in the same cycle. A rotating scheduler drains the queues one word per cycle.

The two words of a pair always leave back to back, with the smaller index first. The scheduler passes over lanes that hold nothing without spending a cycle on them. When any lane is close to full, the block asks the comparator to pause its sweep. The block counts the pairs it has fully emitted. A start pulse clears this count at the beginning of each update pass. A done flag rises once the comparator has reported the end of its sweep and every queued word has left.

Top module: `coll_serializer`

## Requirements
- R1: After reset, word_valid, stall and done are low and coll_count is zero.
- R2: Each stored pair is emitted as two consecutive accepted words, the smaller index first. No word of another pair comes between them.
- R3: Lanes are served in rotation. After the pair of lane L completes, the search for the next pair begins at lane L+1, wrapping to lane 0 after the last lane.
- R4: Lanes that hold no pair are skipped. While any pair is queued, word_valid stays high with no idle cycle.
- R5: While word_ready is low, word_valid stays high and word_data holds its value. This holds even when new pairs arrive on lanes that come earlier in the search order.
- R6: stall is high whenever any lane has fewer than two free pair slots. A pair that arrives in the cycle after stall rises is still stored and emitted.
- R7: coll_count rises by one when the second word of a pair is accepted. A start pulse clears it. If start and that second word fall in the same cycle, coll_count becomes 1.
- R8: done is high only when src_done has been seen since the last start and no word is waiting. A start pulse clears it.
- R9: Pairs presented on several lanes in the same cycle are all stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start of an update pass: clears the count and the seen-done flag |
| pair_valid | input | LANES | One bit per lane: a pair is present on that lane |
| pair_a | input | LANES*IDXW | First index of each lane's pair |
| pair_b | input | LANES*IDXW | Second index of each lane's pair |
| src_done | input | 1 | Comparator has finished its sweep |
| stall | output | 1 | Pause request to the comparator |
| word_valid | output | 1 | Output word available |
| word_ready | input | 1 | Sink accepts the word this cycle |
| word_data | output | IDXW | Output index word |
| coll_count | output | CNTW | Pairs fully emitted in this pass |
| done | output | 1 | Pass finished and all queues empty |

## Verification
Two events can meet in one cycle: a start pulse that clears the count, and the acceptance of a second word that would add to it. The bench brings this about by holding a pair's second word on the output with word_ready high and pulsing start in that same cycle. The count must then read 1, not 0 and not the old value plus one. A second overlap happens when a pair arrives on an earlier lane while a word is held by back-pressure. Here the held word must not change, and both pairs must still leave in order.

// File: rtl/coll_serializer.sv
module coll_serializer #(
  parameter int LANES = 3,
  parameter int IDXW  = 9,
  parameter int DEPTH = 4,
  parameter int CNTW  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [LANES-1:0]      pair_valid,
  input  logic [LANES*IDXW-1:0] pair_a,
  input  logic [LANES*IDXW-1:0] pair_b,
  input  logic                  src_done,
  output logic                  stall,
  output logic                  word_valid,
  input  logic                  word_ready,
  output logic [IDXW-1:0]       word_data,
  output logic [CNTW-1:0]       coll_count,
  output logic                  done
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [IDXW-1:0]  lo_head [LANES];
  logic [IDXW-1:0]  hi_head [LANES];
  logic [LANES-1:0] lo_nonempty, lane_full, lane_tight, push, pop_lo, pop_hi;

  logic          busy, phase, any, fire, seen;
  logic [LW-1:0] lock, rr, pick, sel;

  assign sel        = busy ? lock : pick;
  assign word_valid = busy | any;
  assign word_data  = phase ? hi_head[sel] : lo_head[sel];
  assign fire       = word_valid & word_ready;
  assign stall      = |lane_tight;
  assign done       = seen & ~word_valid;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IDXW-1:0] a, b, mn, mx;
    logic [IDXW-1:0] lo_mem [DEPTH];
    logic [IDXW-1:0] hi_mem [DEPTH];
    logic [AW-1:0]   wp, lo_rp, hi_rp;
    logic [AW:0]     lo_cnt, hi_cnt;

    assign a  = pair_a[l*IDXW +: IDXW];
    assign b  = pair_b[l*IDXW +: IDXW];
    assign mn = (a < b) ? a : b;
    assign mx = (a < b) ? b : a;

    assign lane_full[l]   = (hi_cnt == (AW+1)'(DEPTH));
    assign lane_tight[l]  = (hi_cnt > (AW+1)'(DEPTH - 2));
    assign lo_nonempty[l] = (lo_cnt != '0);
    assign push[l]        = pair_valid[l] & ~lane_full[l];
    assign pop_lo[l]      = fire & ~phase & (sel == LW'(l));
    assign pop_hi[l]      = fire &  phase & (sel == LW'(l));
    assign lo_head[l]     = lo_mem[lo_rp];
    assign hi_head[l]     = hi_mem[hi_rp];

    always_ff @(posedge clk) begin
      if (push[l]) begin
        lo_mem[wp] <= mn;
        hi_mem[wp] <= mx;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp     <= '0;
        lo_rp  <= '0;
        hi_rp  <= '0;
        lo_cnt <= '0;
        hi_cnt <= '0;
      end else begin
        if (push[l]) wp <= wp + 1'b1;
        if (pop_lo[l]) lo_rp <= lo_rp + 1'b1;
        if (pop_hi[l]) hi_rp <= hi_rp + 1'b1;
        lo_cnt <= lo_cnt + (AW+1)'(push[l]) - (AW+1)'(pop_lo[l]);
        hi_cnt <= hi_cnt + (AW+1)'(push[l]) - (AW+1)'(pop_hi[l]);
      end
    end
  end

  always_comb begin
    any  = 1'b0;
    pick = rr;
    for (int k = LANES - 1; k >= 0; k--) begin
      int t;
      t = int'(rr) + k;
      if (t >= LANES) t = t - LANES;
      if (lo_nonempty[t]) begin
        any  = 1'b1;
        pick = LW'(t);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      phase      <= 1'b0;
      lock       <= '0;
      rr         <= '0;
      coll_count <= '0;
      seen       <= 1'b0;
    end else begin
      if (fire && phase) begin
        busy  <= 1'b0;
        phase <= 1'b0;
        rr    <= (lock == LW'(LANES - 1)) ? '0 : lock + 1'b1;
      end else if (fire) begin
        busy  <= 1'b1;
        phase <= 1'b1;
        lock  <= sel;
      end else if (word_valid) begin
        busy <= 1'b1;
        lock <= sel;
      end
      coll_count <= (start ? '0 : coll_count) + CNTW'(fire & phase);
      seen       <= start ? 1'b0 : (seen | src_done);
    end
  end
endmodule

module coll_serializer_chk #(
  parameter int LANES = 3,
  parameter int IDXW  = 9,
  parameter int CNTW  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LANES-1:0] pair_valid,
  input logic [LANES-1:0] lane_full,
  input logic             phase,
  input logic             stall,
  input logic             word_valid,
  input logic             word_ready,
  input logic [IDXW-1:0]  word_data,
  input logic [CNTW-1:0]  coll_count,
  input logic             done
);
  a_r2_second_word_next: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_ready && !phase |=> word_valid && phase);

  a_r5_hold_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |=> word_valid && $stable(word_data));

  a_r6_stall_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_full) |-> stall);

  a_r6_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> !(|(pair_valid & lane_full)));

  a_r7_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !(word_valid && word_ready && phase) |=> $stable(coll_count));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !word_valid);
endmodule

bind coll_serializer coll_serializer_chk #(.LANES(LANES), .IDXW(IDXW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pair_valid(pair_valid),
  .lane_full(lane_full), .phase(phase), .stall(stall), .word_valid(word_valid),
  .word_ready(word_ready), .word_data(word_data), .coll_count(coll_count), .done(done)
);

// File: tb/sim_coll_serializer.sv
module sim_coll_serializer;
  localparam int PERIOD = 10;
  localparam int LANES  = 3;
  localparam int IDXW   = 9;
  localparam int CNTW   = 16;

  logic clk = 0, rst_n = 0, start = 0, src_done = 0, word_ready = 0;
  logic [LANES-1:0] pair_valid = '0;
  logic [LANES*IDXW-1:0] pair_a = '0, pair_b = '0;
  logic stall, word_valid, done;
  logic [IDXW-1:0] word_data;
  logic [CNTW-1:0] coll_count;
  int n_chk = 0, n_fail = 0;

  coll_serializer #(.LANES(LANES), .IDXW(IDXW), .DEPTH(4), .CNTW(CNTW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pair_valid(pair_valid),
    .pair_a(pair_a), .pair_b(pair_b), .src_done(src_done), .stall(stall),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .coll_count(coll_count), .done(done));

  always #(PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int lane, input int a, input int b);
    pair_valid[lane] = 1'b1;
    pair_a[lane*IDXW +: IDXW] = IDXW'(a);
    pair_b[lane*IDXW +: IDXW] = IDXW'(b);
  endtask

  task automatic push_now();
    tick();
    pair_valid = '0;
  endtask

  task automatic expect_word(input int v, input string req);
    word_ready = 1'b1;
    check(word_valid == 1'b1, req, int'(word_valid), 1);
    check(int'(word_data) == v, req, int'(word_data), v);
    tick();
    word_ready = 1'b0;
  endtask

  task automatic t_reset();
    check(!word_valid, "R1", int'(word_valid), 0);
    check(!stall, "R1", int'(stall), 0);
    check(!done, "R1", int'(done), 0);
    check(coll_count == 0, "R1", int'(coll_count), 0);
  endtask

  task automatic t_burst();
    put(0, 5, 2); put(1, 7, 9); put(2, 300, 1);
    push_now();
    expect_word(2, "R9/R2 lane0 lo");
    expect_word(5, "R2 lane0 hi");
    expect_word(7, "R3/R4 lane1 lo");
    expect_word(9, "R2 lane1 hi");
    expect_word(1, "R3 lane2 lo");
    expect_word(300, "R2 lane2 hi");
    check(!word_valid, "R4 drained", int'(word_valid), 0);
    check(coll_count == 3, "R7", int'(coll_count), 3);
  endtask

  task automatic t_skip();
    put(1, 20, 21); put(2, 10, 11);
    push_now();
    expect_word(20, "R4 skip lane0");
    expect_word(21, "R4");
    expect_word(10, "R4");
    expect_word(11, "R4");
    put(0, 30, 31);
    push_now();
    expect_word(30, "R3");
    expect_word(31, "R3");
    put(0, 32, 33); put(1, 34, 35);
    push_now();
    expect_word(34, "R3 rotation lane1 first");
    expect_word(35, "R3");
    expect_word(32, "R3 wrap to lane0");
    expect_word(33, "R3");
    check(coll_count == 8, "R7", int'(coll_count), 8);
  endtask

  task automatic t_backpressure();
    put(2, 41, 40);
    push_now();
    for (int i = 0; i < 3; i++) begin
      if (i == 1) put(1, 50, 51);
      check(word_valid && word_data == 40, "R5 hold", int'(word_data), 40);
      tick();
      pair_valid = '0;
    end
    check(word_data == 40, "R5 hold after early-lane push", int'(word_data), 40);
    expect_word(40, "R5");
    expect_word(41, "R2");
    expect_word(50, "R5 later pair");
    expect_word(51, "R5");
    check(coll_count == 10, "R7", int'(coll_count), 10);
  endtask

  task automatic t_stall();
    for (int i = 0; i < 4; i++) begin
      put(0, 61 + 2*i, 60 + 2*i);
      push_now();
      if (i == 1) check(!stall, "R6 two used", int'(stall), 0);
      if (i == 2) check(stall, "R6 one slot left", int'(stall), 1);
    end
    check(stall, "R6 full", int'(stall), 1);
    for (int i = 0; i < 8; i++) expect_word(60 + i, "R6 late pair kept");
    check(!stall, "R6 release", int'(stall), 0);
    check(coll_count == 14, "R7", int'(coll_count), 14);
  endtask

  task automatic t_count_start();
    start = 1'b1;
    tick();
    start = 1'b0;
    check(coll_count == 0, "R7 clear", int'(coll_count), 0);
    put(1, 80, 81);
    push_now();
    expect_word(80, "R7 setup");
    start = 1'b1;
    expect_word(81, "R7 second word");
    start = 1'b0;
    check(coll_count == 1, "R7 start with completion", int'(coll_count), 1);
  endtask

  task automatic t_done();
    put(0, 70, 71);
    push_now();
    src_done = 1'b1;
    tick();
    src_done = 1'b0;
    check(!done, "R8 data pending", int'(done), 0);
    expect_word(70, "R8");
    expect_word(71, "R8");
    check(done, "R8 finished", int'(done), 1);
    start = 1'b1;
    tick();
    start = 1'b0;
    check(!done, "R8 cleared by start", int'(done), 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_burst();
    t_skip();
    t_backpressure();
    t_stall();
    t_count_start();
    t_done();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule